// File: doc/BRIEF.md
# Serial Flash Page-Program Command Engine

This block is the slave side of a serial NOR flash as seen on an SPI bus in mode 0, with one data line in each direction. Three commands are decoded: write-enable (0x06), status read (0x05) and page program (0x02). Page program is taken only if an earlier write-enable set the write-enable latch. It collects 3 or 4 address bytes, as an address-mode input selects, and then loads data bytes into a 256-byte page buffer. The byte offset wraps inside the page. When chip select rises cleanly on a byte boundary and the page lies outside the protected region, a timed program cycle runs. At its end the buffered bytes are ANDed into a small behavioural storage array.

The SPI pins are synchronised into the system clock domain. Each decoder step acts on a detected edge of the serial clock or of chip select. The bus decoder has these states: S_IDLE (chip select high), S_OPCODE (gathering the first byte), S_ADDR (gathering address bytes), S_DATA (loading the page buffer), S_STAT (shifting out status) and S_SKIP (ignoring the rest of a frame). Any state moves to S_IDLE on a chip-select rise and to S_OPCODE on a chip-select fall. S_OPCODE moves to S_STAT, S_ADDR or S_SKIP when its byte completes, and S_ADDR moves to S_DATA after the last address byte. The program engine has three states. P_IDLE moves to P_RUN on a start pulse. P_RUN moves to P_COMMIT after PROG_CYCLES clocks. P_COMMIT writes the page and returns to P_IDLE.

Top module: `spi_page_prog`

## Requirements
- R1: After reset the status byte reads 0x00, spi_miso is 0 and every byte of the storage array reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch, seen as status bit 1. A page program sent while the latch is clear changes nothing.
- R3: After opcode 0x02 the engine takes 3 address bytes, most significant first, when addr4_mode is 0, and 4 bytes when it is 1. In 3-byte mode the top address byte is zero.
- R4: Data bytes are stored at consecutive offsets from the address's low byte. After offset 0xFF the offset returns to 0x00 in the same page. The page is selected by address bits [PAGE_SEL_W+7:8].
- R5: When more than 256 data bytes arrive, each offset keeps the last byte sent to it, so only the final 256 bytes are programmed.
- R6: Programming ANDs each sent byte into the stored byte. Offsets that received no byte keep their value.
- R7: The command is dropped, with storage and the write-enable latch unchanged, if chip select rises with a partial byte received or before any data byte.
- R8: An accepted command starts the program cycle on the chip-select rise. Status bit 0 reads 1 for about PROG_CYCLES clocks and then 0, and storage updates when the cycle ends.
- R9: The write-enable latch clears when the program cycle starts, so status reads 0x01 during the cycle and 0x00 after it.
- R10: With blk_protect = 0 nothing is protected. With a nonzero value B, the top 2^(B-1) 64 KB blocks of the 2^FLASH_AW byte space are protected, and a page program aimed there is dropped with the latch unchanged.
- R11: While the cycle runs, every opcode except 0x05 is ignored: 0x06 does not set the latch.
- R12: After opcode 0x05 the status byte {6'b0, latch, busy} is driven MSB first on spi_miso, changing on SCLK falling edges. It repeats for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial status data out of the block |
| addr4_mode | input | 1 | 1 selects 4 address bytes, 0 selects 3 |
| blk_protect | input | 4 | Block-protect level |
| rd_addr | input | PAGE_SEL_W+8 | Storage array read address |
| rd_data | output | 8 | Storage array byte at rd_addr |

## Verification
The assertions assume that the serial clock and chip select change no faster than every few system clocks. They also assume that spi_mosi settles well before each detected rising edge, and that addr4_mode and blk_protect hold steady for a whole frame. The bench keeps four system clocks per SCLK half period and sets data half a period before each rise. It changes the mode and protect inputs only while chip select is high, so every edge is seen once and in order. Expected storage contents and status bytes come from an arithmetic page model in the bench, checked over the whole array after each command.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OPCODE, S_ADDR, S_DATA, S_STAT, S_SKIP
    } bus_state_t;

    typedef enum logic [1:0] {
        P_IDLE, P_RUN, P_COMMIT
    } prog_state_t;

    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDST = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam int PAGE_BYTES = 256;
endpackage

// File: rtl/spi_pp_sync.sv
module spi_pp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[STAGES-1:0], sclk};
            cs_p   <= {cs_p[STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
    assign cs_fall   = ~cs_p[STAGES-1] & cs_p[STAGES];
    assign cs_rise   = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_pp_array.sv
module spi_pp_array
    import spi_pp_pkg::*;
#(
    parameter int PAGE_SEL_W  = 2,
    parameter int PROG_CYCLES = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    buf_clear,
    input  logic                    buf_wr,
    input  logic [7:0]              buf_off,
    input  logic [7:0]              buf_data,
    input  logic                    go,
    input  logic [PAGE_SEL_W-1:0]   go_page,
    output logic                    busy,
    input  logic [PAGE_SEL_W+7:0]   rd_addr,
    output logic [7:0]              rd_data
);
    localparam int MEM_AW    = PAGE_SEL_W + 8;
    localparam int NUM_BYTES = 1 << MEM_AW;
    localparam int CNT_W     = $clog2(PROG_CYCLES + 1);

    logic [7:0]            mem [NUM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    prog_state_t           state, state_n;
    logic [CNT_W-1:0]      cnt;
    logic [PAGE_SEL_W-1:0] page_q;

    // page buffer data: no reset needed, validity tracked separately
    always_ff @(posedge clk) begin
        if (buf_wr) pbuf[buf_off] <= buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pvalid <= '0;
        else if (buf_clear) pvalid <= '0;
        else if (buf_wr)    pvalid[buf_off] <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            P_IDLE:   if (go) state_n = P_RUN;
            P_RUN:    if (cnt == CNT_W'(PROG_CYCLES - 1)) state_n = P_COMMIT;
            P_COMMIT: state_n = P_IDLE;
            default:  state_n = P_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            page_q <= '0;
            for (int i = 0; i < NUM_BYTES; i++) mem[i] <= 8'hFF;
        end else begin
            if (state == P_IDLE && go) begin
                cnt    <= '0;
                page_q <= go_page;
            end else if (state == P_RUN) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (state == P_COMMIT) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (pvalid[i])
                        mem[{page_q, 8'(i)}] <= mem[{page_q, 8'(i)}] & pbuf[i];
            end
        end
    end

    assign busy    = (state != P_IDLE);
    assign rd_data = mem[rd_addr];

    p_busy_after_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == P_COMMIT |=> state == P_IDLE);
    p_go_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
endmodule

// File: rtl/spi_pp_fsm.sv
module spi_pp_fsm
    import spi_pp_pkg::*;
#(
    parameter int ADDR_BITS  = 25,
    parameter int PAGE_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  mosi_s,
    input  logic                  addr4,
    input  logic [3:0]            bp,
    input  logic                  busy,
    output logic                  miso,
    output logic                  buf_clear,
    output logic                  buf_wr,
    output logic [7:0]            buf_off,
    output logic [7:0]            buf_data,
    output logic                  go,
    output logic [PAGE_SEL_W-1:0] go_page
);
    localparam int unsigned NUM_BLK = 1 << (ADDR_BITS - 16);

    bus_state_t           state, state_n;
    logic [2:0]           bitcnt;
    logic [6:0]           shin;
    logic [7:0]           rx_byte, shout, off;
    logic [ADDR_BITS-1:0] addr_q;
    logic [1:0]           abytes;
    logic                 got_data, wel, byte_done, accept, last_addr, prot;
    logic [31:0]          span, blk_ext;

    assign rx_byte   = {shin, mosi_s};
    assign byte_done = sclk_rise && (bitcnt == 3'd7) && (state != S_IDLE);
    assign accept    = byte_done && state == S_OPCODE && rx_byte == OP_PROG && wel && !busy;
    assign last_addr = abytes == (addr4 ? 2'd3 : 2'd2);

    always_comb begin
        blk_ext = 32'(addr_q[ADDR_BITS-1:16]);
        span    = 32'd1 << (bp - 4'd1);
        prot    = (bp != 4'd0) && (blk_ext + span >= NUM_BLK);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (cs_rise)      state_n = S_IDLE;
        else if (cs_fall) state_n = S_OPCODE;
        else if (byte_done) begin
            unique case (state)
                S_OPCODE: begin
                    if (rx_byte == OP_RDST) state_n = S_STAT;
                    else if (accept)        state_n = S_ADDR;
                    else                    state_n = S_SKIP;
                end
                S_ADDR:  if (last_addr) state_n = S_DATA;
                default: state_n = state;
            endcase
        end
    end

    assign go        = cs_rise && state == S_DATA && got_data && bitcnt == 3'd0 && !prot;
    assign buf_clear = accept;
    assign buf_wr    = byte_done && state == S_DATA;
    assign buf_off   = off;
    assign buf_data  = rx_byte;
    assign go_page   = addr_q[PAGE_SEL_W+7:8];

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shin     <= '0;
            shout    <= '0;
            off      <= '0;
            addr_q   <= '0;
            abytes   <= '0;
            got_data <= 1'b0;
            wel      <= 1'b0;
            miso     <= 1'b0;
        end else begin
            if (cs_fall) bitcnt <= '0;
            else if (sclk_rise && state != S_IDLE) begin
                bitcnt <= bitcnt + 3'd1;
                shin   <= {shin[5:0], mosi_s};
            end
            if (accept) begin
                addr_q   <= '0;
                abytes   <= '0;
                got_data <= 1'b0;
            end
            if (byte_done && state == S_OPCODE && rx_byte == OP_WREN && !busy)
                wel <= 1'b1;
            else if (go)
                wel <= 1'b0;
            if (byte_done && state == S_ADDR) begin
                addr_q <= {addr_q[ADDR_BITS-9:0], rx_byte};
                abytes <= abytes + 2'd1;
                if (last_addr) off <= rx_byte;
            end
            if (buf_wr) begin
                off      <= off + 8'd1;
                got_data <= 1'b1;
            end
            if (byte_done && (state == S_STAT || (state == S_OPCODE && rx_byte == OP_RDST)))
                shout <= {6'd0, wel, busy};
            else if (sclk_fall && state == S_STAT)
                shout <= {shout[6:0], 1'b0};
            if (cs_rise)
                miso <= 1'b0;
            else if (sclk_fall && state == S_STAT)
                miso <= shout[7];
        end
    end

    p_go_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> wel);
    p_wel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !wel);
    p_miso_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_rise) |=> $stable(miso));
endmodule

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
    parameter int FLASH_AW    = 25,
    parameter int PAGE_SEL_W  = 2,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    input  logic                  addr4_mode,
    input  logic [3:0]            blk_protect,
    input  logic [PAGE_SEL_W+7:0] rd_addr,
    output logic [7:0]            rd_data
);
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
    logic buf_clear, buf_wr, go, busy;
    logic [7:0] buf_off, buf_data;
    logic [PAGE_SEL_W-1:0] go_page;

    spi_pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_pp_fsm #(.ADDR_BITS(FLASH_AW), .PAGE_SEL_W(PAGE_SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s), .addr4(addr4_mode),
        .bp(blk_protect), .busy(busy), .miso(spi_miso), .buf_clear(buf_clear),
        .buf_wr(buf_wr), .buf_off(buf_off), .buf_data(buf_data), .go(go),
        .go_page(go_page)
    );

    spi_pp_array #(.PAGE_SEL_W(PAGE_SEL_W), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_wr(buf_wr),
        .buf_off(buf_off), .buf_data(buf_data), .go(go), .go_page(go_page),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/test_spi_page_prog.sv
module test_spi_page_prog;
    localparam int PSW   = 2;
    localparam int NB    = 1 << (PSW + 8);
    localparam int PCYC  = 600;
    localparam int HALF  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, a4 = 1'b0;
    logic [3:0] bp = 4'd0;
    logic [PSW+7:0] rd_addr = '0;
    logic miso;
    logic [7:0] rd_data;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_mem [NB];
    logic [7:0] dbuf [600];
    logic [7:0] st;

    always #10 clk = ~clk;

    spi_page_prog #(.FLASH_AW(25), .PAGE_SEL_W(PSW), .PROG_CYCLES(PCYC)) i_spi_page_prog (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .addr4_mode(a4), .blk_protect(bp), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_end;
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic wren;
        logic [7:0] d;
        cs_begin; xfer(8'h06, 8, d); cs_end;
    endtask

    task automatic read_status(output logic [7:0] s, output logic [7:0] s2);
        logic [7:0] d;
        cs_begin; xfer(8'h05, 8, d); xfer(8'h00, 8, s); xfer(8'h00, 8, s2); cs_end;
    endtask

    task automatic wait_idle;
        logic [7:0] s, s2;
        for (int k = 0; k < 60; k++) begin
            read_status(s, s2);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic prog_cmd(input logic [31:0] a, input int n, input int extra);
        logic [7:0] d;
        cs_begin;
        xfer(8'h02, 8, d);
        if (a4) xfer(a[31:24], 8, d);
        xfer(a[23:16], 8, d); xfer(a[15:8], 8, d); xfer(a[7:0], 8, d);
        for (int k = 0; k < n; k++) xfer(dbuf[k], 8, d);
        if (extra > 0) xfer(dbuf[n], extra, d);
        cs_end;
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 600; k++) dbuf[k] = 8'((k * 37 + seed * 11) ^ (k >> 3) ^ seed);
    endtask

    // arithmetic page model: last byte per offset wins, then AND into the page
    task automatic model_prog(input logic [31:0] a, input int n);
        logic [7:0] pb [256];
        logic       pv [256];
        int         pg;
        for (int k = 0; k < 256; k++) pv[k] = 1'b0;
        for (int k = 0; k < n; k++) begin
            pb[(a[7:0] + k) % 256] = dbuf[k];
            pv[(a[7:0] + k) % 256] = 1'b1;
        end
        pg = int'(a[PSW+7:8]);
        for (int k = 0; k < 256; k++)
            if (pv[k]) exp_mem[pg * 256 + k] = exp_mem[pg * 256 + k] & pb[k];
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < NB; i++) begin
            rd_addr = (PSW + 8)'(i);
            #1;
            if (rd_data !== exp_mem[i]) begin
                bad++;
                if (bad < 4) chk(1'b0, $sformatf("%s byte %0d", tag, i), int'(rd_data), int'(exp_mem[i]));
            end
        end
        if (bad == 0) chk(1'b1, tag, 0, 0);
        @(negedge clk);
    endtask

    task automatic chk_status(input logic [7:0] exp, input string tag);
        logic [7:0] s, s2;
        read_status(s, s2);
        chk(s == exp, tag, int'(s), int'(exp));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] s, s2;
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        chk(miso == 1'b0, "R1 miso idle", int'(miso), 0);
        chk_status(8'h00, "R1 status after reset");
        check_mem("R1 array all 0xFF");

        // R2: program without write-enable is ignored
        fill(1);
        prog_cmd(32'h0000_0010, 3, 0);
        chk_status(8'h00, "R2 no cycle without latch");
        check_mem("R2 array unchanged");

        // R2/R12: latch set, status repeats while selected
        wren;
        read_status(s, s2);
        chk(s == 8'h02, "R2 latch set", int'(s), 8'h02);
        chk(s2 == 8'h02, "R12 status repeats", int'(s2), 8'h02);

        // R8/R9/R11: executed program, status during the cycle
        fill(2);
        prog_cmd(32'h0000_0020, 5, 0);
        model_prog(32'h0000_0020, 5);
        chk_status(8'h01, "R8 R9 busy with latch cleared");
        wren;
        chk_status(8'h01, "R11 write-enable ignored while busy");
        wait_idle;
        chk_status(8'h00, "R9 idle status");
        check_mem("R4 R8 five bytes programmed");

        // R4: wrap within page 1
        wren; fill(3);
        prog_cmd(32'h0000_01F0, 40, 0);
        model_prog(32'h0000_01F0, 40);
        wait_idle;
        check_mem("R4 wrap inside page");

        // R6: AND over already programmed bytes
        wren; fill(4);
        prog_cmd(32'h0000_001E, 10, 0);
        model_prog(32'h0000_001E, 10);
        wait_idle;
        check_mem("R6 and-programming");

        // R5: more than 256 bytes
        wren; fill(5);
        prog_cmd(32'h0000_0237, 300, 0);
        model_prog(32'h0000_0237, 300);
        wait_idle;
        check_mem("R5 last 256 bytes kept");

        // R7: partial byte and no data byte
        wren; fill(6);
        prog_cmd(32'h0000_0300, 3, 3);
        chk_status(8'h02, "R7 partial byte dropped latch kept");
        prog_cmd(32'h0000_0300, 0, 0);
        chk_status(8'h02, "R7 no data dropped latch kept");
        check_mem("R7 array unchanged");

        // R10/R3: protection in 4-byte mode
        a4 = 1'b1; bp = 4'd1;
        fill(7);
        prog_cmd(32'h01FF_0300, 4, 0);
        chk_status(8'h02, "R10 top block protected");
        check_mem("R10 array unchanged");
        prog_cmd(32'h01FE_0300, 4, 0);
        model_prog(32'h01FE_0300, 4);
        chk_status(8'h01, "R10 block below range runs");
        wait_idle;
        check_mem("R3 four address bytes");

        // R10: level 10 covers everything, level 0 nothing
        a4 = 1'b0; bp = 4'd10;
        wren; fill(8);
        prog_cmd(32'h0000_0100, 6, 0);
        chk_status(8'h02, "R10 whole space protected");
        bp = 4'd0;
        prog_cmd(32'h0000_0100, 6, 0);
        model_prog(32'h0000_0100, 6);
        wait_idle;
        check_mem("R3 R10 three-byte mode unprotected");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule